// File: doc/BRIEF.md
# Sensor Register Serial Master

This block talks to an image sensor's control registers over a two-wire serial bus (I2C). It runs one transaction at a time. A write transaction sets one register. A read transaction returns one register. The clock line is driven as a push-pull output. The data line is open-drain: the block only pulls it low, through an output enable, and reads the wired level back on `sda_in`.

Every change of line level is one "step". Each step is held for a parameterised number of clock cycles. The default of 400 cycles at 100 MHz gives roughly 4 µs per step.

A read is built from two transactions:
- The first frame addresses the device in write direction and sends the register index. It closes with a full STOP.
- A fresh START then opens the second frame. It carries the device address with the read bit set, clocks in eight bits, and answers them with a not-acknowledge.

If any acknowledge slot sees the line high, the block does three things. It raises a sticky error, drops the remaining bytes and closes the bus with a STOP. While the error stays raised, every later request is skipped. Only `err_clr` clears it.

Top module: `sreg_i2c_master`

## Requirements
- R1: While reset is active, and on leaving it, `scl` is 1, `sda_oe` is 0, and `busy`, `done` and `err` are 0. Whenever `busy` is 0, `scl` stays 1 and `sda_oe` stays 0.
- R2: With `rd_mode`=0, a request produces one frame: START, byte `{dev_addr,0}`, ack slot, `reg_addr`, ack slot, `wr_data`, ack slot, STOP. The addressed device then holds `wr_data` at `reg_addr`.
- R3: With `rd_mode`=1, the block first sends START, `{dev_addr,0}`, ack slot, `reg_addr`, ack slot and STOP. It then sends a new START, `{dev_addr,1}` and an ack slot, and clocks in eight bits MSB first into `rd_data`. There are exactly two STARTs and two STOPs, with no START between a START and its STOP.
- R4: Bytes are sent MSB first. SDA never changes while SCL is high, except for START (SDA falling) and STOP (SDA rising). SDA and SCL never change in the same cycle.
- R5: The master releases SDA (`sda_oe`=0) for every ack slot and every received bit. It answers the received byte with SDA high on the ninth clock.
- R6: A high level sampled in any ack slot sets `err`. The remaining bytes are skipped and a STOP ends the frame. An address that is not acknowledged ends a request after 32 steps.
- R7: `err` stays 1 until `err_clr`. A request made while `err` is 1 gives `done` in the next cycle, leaves `busy` at 0 and causes no line activity.
- R8: If a missing acknowledge and `err_clr` fall in the same cycle, `err` ends up 1.
- R9: `start` is ignored while `busy` is 1. `done` is a one-cycle pulse, raised in the cycle in which `busy` falls.
- R10: Each step lasts STEP_CYCLES cycles. Counting the clock edge that accepts `start` as edge 1, `done` is first seen after edge 1 + N·STEP_CYCLES. N is 86 for a write, 109 for a read and 32 for an unacknowledged address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a transaction (accepted only while idle) |
| rd_mode | input | 1 | 1 = register read, 0 = register write |
| dev_addr | input | 7 | Seven-bit device address |
| reg_addr | input | 8 | Register index |
| wr_data | input | 8 | Byte to write |
| err_clr | input | 1 | Clears the sticky error |
| sda_in | input | 1 | Wired level of the data line |
| scl | output | 1 | Serial clock line |
| sda_oe | output | 1 | 1 pulls the data line low |
| rd_data | output | 8 | Last byte received |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Sticky missing-acknowledge flag |

## Verification
Setting the error from a missing acknowledge and clearing it through `err_clr` can land in the same cycle. The bench provokes this by addressing a device that does not answer. It raises `err_clr` for exactly the cycle whose closing edge samples the first ack slot, which is step 28 of the request. The flag must read 1 afterwards.

A second pairing places a new `start` in the middle of a running write. The write must finish with its original operands and its normal length. All bus checks are made by a behavioural device on the wires, which decodes START, STOP, bytes and acknowledges from the line levels alone.

// File: rtl/sreg_i2c_pkg.sv
`timescale 1ns/1ps
package sreg_i2c_pkg;

  typedef enum logic [2:0] {OP_START, OP_TX, OP_ACK, OP_RX, OP_NACK, OP_STOP} op_e;
  typedef enum logic [1:0] {BY_ADDR_W, BY_REG, BY_DATA, BY_ADDR_R} bsel_e;

  typedef struct packed {
    op_e   op;
    bsel_e bsel;
  } seg_t;

  localparam int unsigned SEG_W = 4;
  localparam logic [SEG_W-1:0] WR_LAST_SEG = 4'd7;
  localparam logic [SEG_W-1:0] RD_MID_STOP = 4'd5;
  localparam logic [SEG_W-1:0] RD_LAST_SEG = 4'd11;

  // Segment list of one request; the order is the bus protocol itself.
  function automatic seg_t seg_decode(input logic [SEG_W-1:0] seg, input logic rd);
    seg_t s;
    s.op   = OP_STOP;
    s.bsel = BY_ADDR_W;
    if (!rd) begin
      case (seg)
        4'd0:                s.op = OP_START;
        4'd1:                begin s.op = OP_TX; s.bsel = BY_ADDR_W; end
        4'd3:                begin s.op = OP_TX; s.bsel = BY_REG;    end
        4'd5:                begin s.op = OP_TX; s.bsel = BY_DATA;   end
        4'd2, 4'd4, 4'd6:    s.op = OP_ACK;
        default:             s.op = OP_STOP;
      endcase
    end else begin
      case (seg)
        4'd0, 4'd6:          s.op = OP_START;
        4'd1:                begin s.op = OP_TX; s.bsel = BY_ADDR_W; end
        4'd3:                begin s.op = OP_TX; s.bsel = BY_REG;    end
        4'd7:                begin s.op = OP_TX; s.bsel = BY_ADDR_R; end
        4'd2, 4'd4, 4'd8:    s.op = OP_ACK;
        4'd9:                s.op = OP_RX;
        4'd10:               s.op = OP_NACK;
        default:             s.op = OP_STOP;
      endcase
    end
    return s;
  endfunction

  // Index of the final sub-step of each operation.
  function automatic logic [1:0] last_sub(input op_e op);
    case (op)
      OP_START, OP_RX, OP_NACK: return 2'd1;
      default:                  return 2'd2;
    endcase
  endfunction

  // Line levels {scl, sda_high} for one sub-step.
  function automatic logic [1:0] line_levels(input op_e op, input logic [1:0] sub, input logic b);
    case (op)
      OP_START: return (sub == 2'd0) ? 2'b10 : 2'b00;
      OP_TX:    return {sub == 2'd1, b};
      OP_ACK:   return {sub == 2'd1, 1'b1};
      OP_RX,
      OP_NACK:  return {sub == 2'd0, 1'b1};
      default:  return (sub == 2'd0) ? 2'b00 : ((sub == 2'd1) ? 2'b10 : 2'b11);
    endcase
  endfunction

endpackage

// File: rtl/sreg_i2c_step_timer.sv
`timescale 1ns/1ps
module sreg_i2c_step_timer #(
  parameter int unsigned STEP_CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic step_end
);
  localparam int unsigned CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign step_end = run && (cnt_q == LAST);

  always_comb begin
    if (!run || step_end) cnt_d = '0;
    else                  cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sreg_i2c_line_reg.sv
`timescale 1ns/1ps
module sreg_i2c_line_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic scl_d,
  input  logic sda_hi_d,
  output logic scl,
  output logic sda_oe
);
  logic scl_q, sda_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b1;
      sda_hi_q <= 1'b1;
    end else if (en) begin
      scl_q    <= scl_d;
      sda_hi_q <= sda_hi_d;
    end
  end

  assign scl    = scl_q;
  assign sda_oe = ~sda_hi_q;
endmodule

// File: rtl/sreg_i2c_master.sv
`timescale 1ns/1ps
module sreg_i2c_master
  import sreg_i2c_pkg::*;
#(
  parameter int unsigned STEP_CYCLES = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rd_mode,
  input  logic [6:0] dev_addr,
  input  logic [7:0] reg_addr,
  input  logic [7:0] wr_data,
  input  logic       err_clr,
  input  logic       sda_in,
  output logic       scl,
  output logic       sda_oe,
  output logic [7:0] rd_data,
  output logic       busy,
  output logic       done,
  output logic       err
);
  // Reset: asserted at once, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic             busy_q, busy_n, done_q, done_n, err_q, err_n, abort_q, abort_n, rd_q, rd_n;
  logic [SEG_W-1:0] seg_q, seg_n, stop_seg;
  logic [1:0]       sub_q, sub_n;
  logic [2:0]       bit_q, bit_n;
  logic [7:0]       rdata_q, rdata_n, reg_q, dat_q, nxt_byte;
  logic [6:0]       addr_q;
  logic             load, step_end, line_en;
  logic [1:0]       line_n;
  seg_t             cur, nxt;

  sreg_i2c_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_s), .run(busy_q), .step_end(step_end)
  );

  assign load     = start && !busy_q && !err_q;
  assign cur      = seg_decode(seg_q, rd_q);
  assign stop_seg = !rd_q ? WR_LAST_SEG : ((seg_q < RD_MID_STOP) ? RD_MID_STOP : RD_LAST_SEG);

  always_comb begin
    busy_n  = busy_q;
    done_n  = 1'b0;
    err_n   = err_q;
    abort_n = abort_q;
    rd_n    = rd_q;
    seg_n   = seg_q;
    sub_n   = sub_q;
    bit_n   = bit_q;
    rdata_n = rdata_q;
    if (err_clr) err_n = 1'b0;
    if (!busy_q) begin
      if (start) begin
        if (err_q) begin
          done_n = 1'b1;
        end else begin
          busy_n  = 1'b1;
          rd_n    = rd_mode;
          seg_n   = '0;
          sub_n   = 2'd0;
          bit_n   = 3'd7;
          abort_n = 1'b0;
        end
      end
    end else if (step_end) begin
      if (cur.op == OP_ACK && sub_q == 2'd1 && sda_in) begin
        err_n   = 1'b1;
        abort_n = 1'b1;
      end
      if (cur.op == OP_RX && sub_q == 2'd0) rdata_n = {rdata_q[6:0], sda_in};
      if (sub_q != last_sub(cur.op)) begin
        sub_n = sub_q + 2'd1;
      end else begin
        sub_n = 2'd0;
        if ((cur.op == OP_TX || cur.op == OP_RX) && bit_q != 3'd0) begin
          bit_n = bit_q - 3'd1;
        end else begin
          bit_n = 3'd7;
          if (cur.op == OP_STOP && (abort_q || seg_q == (rd_q ? RD_LAST_SEG : WR_LAST_SEG))) begin
            busy_n = 1'b0;
            done_n = 1'b1;
          end else if (cur.op == OP_ACK && abort_q) begin
            seg_n = stop_seg;
          end else begin
            seg_n = seg_q + 4'd1;
          end
        end
      end
    end
  end

  // Line levels of the step about to begin, registered with the state.
  assign nxt = seg_decode(seg_n, rd_n);
  always_comb begin
    case (nxt.bsel)
      BY_ADDR_W: nxt_byte = {addr_q, 1'b0};
      BY_REG:    nxt_byte = reg_q;
      BY_DATA:   nxt_byte = dat_q;
      default:   nxt_byte = {addr_q, 1'b1};
    endcase
    line_n = busy_n ? line_levels(nxt.op, sub_n, nxt_byte[bit_n]) : 2'b11;
  end
  assign line_en = busy_q || busy_n;

  sreg_i2c_line_reg u_lines (
    .clk(clk), .rst_n(rst_s), .en(line_en),
    .scl_d(line_n[1]), .sda_hi_d(line_n[0]),
    .scl(scl), .sda_oe(sda_oe)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      abort_q <= 1'b0;
      rd_q    <= 1'b0;
      seg_q   <= '0;
      sub_q   <= 2'd0;
      bit_q   <= 3'd7;
      rdata_q <= 8'h00;
    end else begin
      busy_q  <= busy_n;
      done_q  <= done_n;
      err_q   <= err_n;
      abort_q <= abort_n;
      rd_q    <= rd_n;
      seg_q   <= seg_n;
      sub_q   <= sub_n;
      bit_q   <= bit_n;
      rdata_q <= rdata_n;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      addr_q <= 7'h00;
      reg_q  <= 8'h00;
      dat_q  <= 8'h00;
    end else if (load) begin
      addr_q <= dev_addr;
      reg_q  <= reg_addr;
      dat_q  <= wr_data;
    end
  end

  assign rd_data = rdata_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign err     = err_q;
endmodule

// File: rtl/sreg_i2c_master_chk.sv
`timescale 1ns/1ps
module sreg_i2c_master_chk #(
  parameter int unsigned STEP_CYCLES = 400
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic err_clr,
  input logic scl,
  input logic sda_oe,
  input logic done,
  input logic busy,
  input logic err
);
  localparam int unsigned HW = $clog2(STEP_CYCLES + 2) + 1;
  localparam logic [HW-1:0] HMAX = {HW{1'b1}};

  logic [1:0]    lines_prev;
  logic [HW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_prev <= 2'b10;
      hold_q     <= '0;
    end else begin
      lines_prev <= {scl, sda_oe};
      if ({scl, sda_oe} != lines_prev) hold_q <= HW'(1);
      else if (hold_q != HMAX)         hold_q <= hold_q + HW'(1);
    end
  end

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (scl && !sda_oe));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr) |=> err);

  assert_skip_on_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && err) |=> (done && !busy));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_with_busy_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_step_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && ({scl, sda_oe} != lines_prev)) |-> (hold_q >= HW'(STEP_CYCLES)));
endmodule

bind sreg_i2c_master sreg_i2c_master_chk #(.STEP_CYCLES(STEP_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .err_clr(err_clr), .scl(scl),
  .sda_oe(sda_oe), .done(done), .busy(busy), .err(err)
);

// File: tb/sreg_i2c_master_test.sv
`timescale 1ns/1ps
module sreg_i2c_master_test;
  localparam int STEP = 4;
  localparam logic [6:0] SLV = 7'h21;
  localparam int WR_STEPS = 86, RD_STEPS = 109, ANACK_STEPS = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, rd_mode = 1'b0, err_clr = 1'b0;
  logic [6:0] dev_addr = 7'h00;
  logic [7:0] reg_addr = 8'h00, wr_data = 8'h00;
  logic scl, sda_oe, busy, done, err, sda_bus;
  logic [7:0] rd_data;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  // Behavioural register device on the wires.
  logic       slv_drv;
  logic [7:0] mem [0:15];
  logic       p_scl, p_sda, active, in_frame, rdm, last_mack;
  logic [3:0] cnt, ptr;
  logic [7:0] sh;
  int         idx, force_nack_idx;
  int         n_start, n_stop, n_restart, n_bad;

  assign sda_bus = !(sda_oe || slv_drv);

  sreg_i2c_master #(.STEP_CYCLES(STEP)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_mode(rd_mode), .dev_addr(dev_addr),
    .reg_addr(reg_addr), .wr_data(wr_data), .err_clr(err_clr), .sda_in(sda_bus),
    .scl(scl), .sda_oe(sda_oe), .rd_data(rd_data), .busy(busy), .done(done), .err(err)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      p_scl <= 1'b1; p_sda <= 1'b1; active <= 1'b0; in_frame <= 1'b0; rdm <= 1'b0;
      cnt <= 4'd0; ptr <= 4'd0; sh <= 8'h00; idx <= 0; slv_drv <= 1'b0; last_mack <= 1'b0;
      n_start <= 0; n_stop <= 0; n_restart <= 0; n_bad <= 0;
      for (int k = 0; k < 16; k++) mem[k] <= 8'(k * 29 + 3);
    end else begin
      p_scl <= scl; p_sda <= sda_bus;
      if ((p_scl != scl) && (p_sda != sda_bus)) n_bad <= n_bad + 1;
      if (p_scl && scl && p_sda && !sda_bus) begin
        n_start <= n_start + 1;
        if (in_frame) n_restart <= n_restart + 1;
        in_frame <= 1'b1; active <= 1'b1; idx <= 0; cnt <= 4'd0; rdm <= 1'b0; slv_drv <= 1'b0;
      end else if (p_scl && scl && !p_sda && sda_bus) begin
        n_stop <= n_stop + 1; in_frame <= 1'b0; active <= 1'b0; slv_drv <= 1'b0;
      end else if (active && !p_scl && scl) begin
        if (cnt == 4'd8 && rdm && idx > 0) last_mack <= sda_bus;
        if (cnt < 4'd8 && !(rdm && idx > 0)) sh <= {sh[6:0], sda_bus};
        cnt <= cnt + 4'd1;
      end else if (active && p_scl && !scl) begin
        if (cnt == 4'd8) begin
          if (rdm && idx > 0) slv_drv <= 1'b0;
          else begin : ackdec
            logic ok;
            ok = (idx != force_nack_idx);
            if (idx == 0) begin ok = ok && (sh[7:1] == SLV); rdm <= sh[0]; end
            if (ok && idx == 1) ptr <= sh[3:0];
            if (ok && idx == 2) mem[ptr] <= sh;
            slv_drv <= ok;
            if (!ok) active <= 1'b0;
          end
        end else if (cnt == 4'd9) begin
          cnt <= 4'd0; idx <= idx + 1;
          slv_drv <= (rdm && idx == 0) ? ~mem[ptr][7] : 1'b0;
        end else if (rdm && idx > 0 && cnt < 4'd8) begin
          slv_drv <= ~mem[ptr][3'(7 - cnt)];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int s0, p0, r0, b0;
  task automatic snap();
    s0 = n_start; p0 = n_stop; r0 = n_restart; b0 = n_bad;
  endtask

  // Issue one request; n = edges until done is seen (accepting edge = 1).
  task automatic txn(input logic rd, input logic [6:0] a, input logic [7:0] r, input logic [7:0] d,
                     input int clr_at, input int inj_at, output int n, output bit act);
    @(negedge clk);
    rd_mode = rd; dev_addr = a; reg_addr = r; wr_data = d; start = 1'b1;
    n = 0; act = 1'b0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
      act = act | sda_oe | !scl;
      start = (n == inj_at);
      if (n == inj_at) rd_mode = ~rd;
      err_clr = (n == clr_at);
    end while (!done && n < 3000);
    start = 1'b0; err_clr = 1'b0;
    chk(n < 3000, "R9 request completes", n, 0);
    @(negedge clk);
    chk(!done && !busy, "R9 done is one cycle", int'(done), 0);
  endtask

  int n; bit act;

  initial begin
    force_nack_idx = -1;
    repeat (3) @(negedge clk);
    chk(scl && !sda_oe && !busy && !done && !err, "R1 in reset", {scl, sda_oe, busy, done, err}, 5'b10000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(scl && !sda_oe && !busy && !done && !err, "R1 after reset", {scl, sda_oe, busy, done, err}, 5'b10000);

    for (int i = 0; i < 48; i++) begin
      logic [7:0] r, d;
      r = 8'(i % 16); d = 8'((i * 37 + 11) ^ (i << 5));
      snap();
      txn(1'b0, SLV, r, d, -1, -1, n, act);
      chk(mem[r[3:0]] == d, "R2 byte stored", mem[r[3:0]], d);
      chk(n == 1 + WR_STEPS * STEP, "R10 write length", n, 1 + WR_STEPS * STEP);
      chk(n_start - s0 == 1 && n_stop - p0 == 1, "R2 one frame", n_start - s0, 1);
      chk(n_bad == b0, "R4 no simultaneous edges", n_bad - b0, 0);
      snap();
      txn(1'b1, SLV, r, 8'h00, -1, -1, n, act);
      chk(rd_data == d, "R3 read data", rd_data, d);
      chk(n == 1 + RD_STEPS * STEP, "R10 read length", n, 1 + RD_STEPS * STEP);
      chk(n_start - s0 == 2 && n_stop - p0 == 2 && n_restart == r0, "R3 stop then start", n_start - s0, 2);
      chk(last_mack == 1'b1, "R5 master nack", last_mack, 1);
      chk(!err, "R5 acks seen", err, 0);
    end

    // R9: start during a write is ignored.
    snap();
    txn(1'b0, SLV, 8'h05, 8'hC3, -1, 40, n, act);
    chk(mem[5] == 8'hC3 && n == 1 + WR_STEPS * STEP, "R9 start while busy ignored", n, 1 + WR_STEPS * STEP);
    chk(n_start - s0 == 1, "R9 single frame", n_start - s0, 1);

    // R6: unanswered address.
    snap();
    txn(1'b0, 7'h33, 8'h06, 8'h99, -1, -1, n, act);
    chk(err == 1'b1, "R6 err on missing ack", err, 1);
    chk(n == 1 + ANACK_STEPS * STEP, "R6 R10 abort length", n, 1 + ANACK_STEPS * STEP);
    chk(n_stop - p0 == 1 && mem[6] != 8'h99, "R6 stop issued, no write", n_stop - p0, 1);

    // R7: skipped while error is set.
    snap();
    txn(1'b0, SLV, 8'h06, 8'h99, -1, -1, n, act);
    chk(n == 1 && !act, "R7 skipped request", n, 1);
    chk(n_start == s0 && mem[6] != 8'h99 && err, "R7 no bus activity", n_start - s0, 0);
    @(negedge clk); err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    chk(!err, "R7 err cleared", err, 0);
    txn(1'b0, SLV, 8'h06, 8'h99, -1, -1, n, act);
    chk(mem[6] == 8'h99 && !err, "R7 works after clear", mem[6], 8'h99);

    // R6: data byte refused; the length stays that of a full write.
    force_nack_idx = 2;
    txn(1'b0, SLV, 8'h07, 8'h44, -1, -1, n, act);
    force_nack_idx = -1;
    chk(err && n == 1 + WR_STEPS * STEP, "R6 data nack", n, 1 + WR_STEPS * STEP);
    @(negedge clk); err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;

    // R8: clear in the cycle that samples the first ack slot.
    txn(1'b0, 7'h33, 8'h01, 8'h00, 28 * STEP, -1, n, act);
    chk(err == 1'b1, "R8 set wins over clear", err, 1);
    @(negedge clk); err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;

    // R6: read with unanswered address.
    snap();
    txn(1'b1, 7'h40, 8'h02, 8'h00, -1, -1, n, act);
    chk(err && n == 1 + ANACK_STEPS * STEP && n_start - s0 == 1, "R6 read address nack", n, 1 + ANACK_STEPS * STEP);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_900_000;
    errors++;
    checks++;
    $display("FAIL R9 watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule